// File: doc/BRIEF.md
# Four-Channel Compare System Timer

This block keeps a 64-bit free-running count that steps once for every cycle in which an external tick enable is high; in a system the enable comes from a clock divider that delivers one pulse per microsecond, so the count is a 1 MHz time base. Next to the count sit four 32-bit compare channels. A channel latches a sticky match flag when the low half of the count steps onto its compare value. Each channel drives its own active-high level interrupt, which stays asserted for as long as the flag is set.

Software reaches the block through a single-cycle 32-bit register port. To schedule a periodic event, it reads the low count word, adds an interval and writes the sum into a compare register. The addition may wrap modulo 2^32, and the wrapped value still matches once the low word wraps around to it. Flags are cleared by writing ones to the status register. Reading the low word also captures the high word, so the two halves of a 64-bit read come from the same instant.

Top module: `systimer_top`

## Requirements
- R1: In reset the count takes the value of parameter START_VALUE (zero by default), every compare register becomes zero, every flag clears and every irq line is low.
- R2: The count grows by exactly one on each clock edge at which tick_en is high and holds when tick_en is low. A carry out of the low 32 bits goes into the high 32 bits.
- R3: Word-aligned byte addresses select the registers. 0x00 is status, with the flags of channels 0..3 in bits 0..3 and zeros above. 0x04 is the low count word, 0x08 is the high count word, and 0x0C, 0x10, 0x14 and 0x18 are the compares of channels 0..3. Unmapped or unaligned addresses read as zero and ignore writes.
- R4: Each compare register can be written and read back as a full 32-bit value. Writes to the two count addresses leave the count unchanged.
- R5: The flag of channel n sets at the clock edge where a tick moves the low count word onto compare n.
- R6: Writing a compare value equal to the current low word does not set the flag. The flag sets only when the count next steps onto that value.
- R7: Flags are sticky. Writing status with bit n at 1 clears flag n, and a 0 in bit n leaves flag n unchanged.
- R8: When a match and a clear of the same flag fall in the same cycle, the flag ends up set.
- R9: irq[n] is high exactly while flag n is set.
- R10: A compare value formed by a 32-bit sum that wrapped past 0xFFFFFFFF matches once the low word wraps around to it.
- R11: A read of the high word returns the high half as it stood at the most recent read of the low word, even after later ticks have carried into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count step enable, one pulse per time unit |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; at the low count word it captures the high half |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr; depends on addr combinationally |
| irq | output | 4 | Level interrupt per channel, bit n for channel n |

## Verification
The bench starts the count just below a 32-bit boundary. This lets it schedule a compare through a wrapped sum and watch the count carry into the high word. A design that compared the full 64 bits or the unwrapped sum would never fire. A design without the capture register would return the new high word in the middle of a 64-bit read. The bench also writes a compare equal to the current count, which a level comparator would flag at once. It clears a flag in the very cycle it matches, which loses the event if the clear takes priority. Finally, it writes zeros to status and writes to the count words, which a wrong decoder would treat as a clear or a load.

// File: rtl/systimer_pkg.sv
package systimer_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned CNT_W  = 64;
    localparam int unsigned NUM_CH = 4;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned SEL_W  = ADDR_W - 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  count_t;

    // Word selector; the order of the compare words matters for channel index.
    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS = 3'd0,
        SEL_CNT_LO = 3'd1,
        SEL_CNT_HI = 3'd2,
        SEL_CMP0   = 3'd3,
        SEL_CMP1   = 3'd4,
        SEL_CMP2   = 3'd5,
        SEL_CMP3   = 3'd6,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
    } bus_op_t;

    // Unaligned accesses decode to nothing.
    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        if (a[1:0] != 2'b00) return SEL_NONE;
        return reg_sel_e'(a[ADDR_W-1:2]);
    endfunction

    function automatic reg_sel_e cmp_sel(input int unsigned ch);
        return reg_sel_e'(SEL_W'(int'(SEL_CMP0) + int'(ch)));
    endfunction

    function automatic word_t status_word(input logic [NUM_CH-1:0] flags);
        return word_t'(flags);
    endfunction

endpackage

// File: rtl/systimer_counter.sv
module systimer_counter
    import systimer_pkg::*;
#(
    parameter count_t START_VALUE = '0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick_en,
    output count_t cnt_q,
    output word_t  next_lo
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= START_VALUE;
        end else if (tick_en) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Low word the count moves to on the coming tick (wraps modulo 2^32).
    assign next_lo = cnt_q[WORD_W-1:0] + WORD_W'(1);

endmodule

// File: rtl/systimer_channel.sv
module systimer_channel
    import systimer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick_en,
    input  word_t next_lo,
    input  logic  cmp_wr,
    input  word_t wr_data,
    input  logic  clr,
    output word_t cmp_q,
    output logic  flag_q
);

    logic hit;

    // Edge-style match: only a tick landing on the value counts.
    assign hit = tick_en && (next_lo == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
        end else if (cmp_wr) begin
            cmp_q <= wr_data;
        end
    end

    // Set has priority over clear so no event is dropped.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/systimer_regif.sv
module systimer_regif
    import systimer_pkg::*;
#(
    parameter word_t SNAP_INIT = '0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_CH-1:0]             clr_mask,
    input  count_t                        cnt,
    input  logic [NUM_CH-1:0][WORD_W-1:0] cmp,
    input  logic [NUM_CH-1:0]             flags,
    output logic [NUM_CH-1:0]             cmp_wr,
    output logic [NUM_CH-1:0]             clr,
    output word_t                         rdata
);

    bus_op_t op;
    word_t   hi_snap_q;

    assign op = '{wr: wr_en, rd: rd_en, sel: decode_addr(addr)};

    // High half captured on every low-word read.
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_snap_q <= SNAP_INIT;
        end else if (op.rd && op.sel == SEL_CNT_LO) begin
            hi_snap_q <= cnt[CNT_W-1:WORD_W];
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch_dec
        assign cmp_wr[g] = op.wr && (op.sel == cmp_sel(g));
        assign clr[g]    = op.wr && (op.sel == SEL_STATUS) && clr_mask[g];
    end

    always_comb begin
        rdata = '0;
        case (op.sel)
            SEL_STATUS: rdata = status_word(flags);
            SEL_CNT_LO: rdata = cnt[WORD_W-1:0];
            SEL_CNT_HI: rdata = hi_snap_q;
            default: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (op.sel == cmp_sel(i)) rdata = cmp[i];
                end
            end
        endcase
    end

endmodule

// File: rtl/systimer_top.sv
module systimer_top
    import systimer_pkg::*;
#(
    parameter count_t START_VALUE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic [NUM_CH-1:0] irq
);

    count_t                        cnt_q;
    word_t                         next_lo;
    logic [NUM_CH-1:0][WORD_W-1:0] cmp_q;
    logic [NUM_CH-1:0]             flag_q;
    logic [NUM_CH-1:0]             cmp_wr;
    logic [NUM_CH-1:0]             clr;

    systimer_counter #(.START_VALUE(START_VALUE)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .cnt_q   (cnt_q),
        .next_lo (next_lo)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        systimer_channel u_chan (
            .clk     (clk),
            .rst     (rst),
            .tick_en (tick_en),
            .next_lo (next_lo),
            .cmp_wr  (cmp_wr[g]),
            .wr_data (wdata),
            .clr     (clr[g]),
            .cmp_q   (cmp_q[g]),
            .flag_q  (flag_q[g])
        );
    end

    systimer_regif #(.SNAP_INIT(START_VALUE[CNT_W-1:WORD_W])) u_regif (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .clr_mask (wdata[NUM_CH-1:0]),
        .cnt      (cnt_q),
        .cmp      (cmp_q),
        .flags    (flag_q),
        .cmp_wr   (cmp_wr),
        .clr      (clr),
        .rdata    (rdata)
    );

    assign irq = flag_q;

endmodule

// File: rtl/systimer_checker.sv
module systimer_checker
    import systimer_pkg::*;
#(
    parameter count_t START_VALUE = '0
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          tick_en,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             addr,
    input logic [WORD_W-1:0]             wdata,
    input logic [NUM_CH-1:0]             irq,
    input count_t                        cnt,
    input logic [NUM_CH-1:0][WORD_W-1:0] cmp
);

    // R1: reset state
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (irq == '0 && cnt == START_VALUE));

    // R2: step on tick
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        tick_en |=> cnt == $past(cnt) + CNT_W'(1));

    // R2: hold without tick
    a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(cnt));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch_chk
        // R5 and R8: a tick onto the compare value always leaves the irq high
        a_r5_match_sets: assert property (@(posedge clk) disable iff (rst)
            (tick_en && (cnt[WORD_W-1:0] + WORD_W'(1)) == cmp[g]) |=> irq[g]);

        // R7: stays set unless a one is written to its status bit
        a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
            (irq[g] && !(wr_en && addr == '0 && wdata[g])) |=> irq[g]);

        // R6: an irq can only rise after a tick
        a_r6_rise_needs_tick: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[g]) |-> $past(tick_en));
    end

endmodule

bind systimer_top systimer_checker #(.START_VALUE(START_VALUE)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .irq     (irq),
    .cnt     (cnt_q),
    .cmp     (cmp_q)
);

// File: tb/systimer_top_tb.sv
module systimer_top_tb;
    import systimer_pkg::*;

    localparam int     CLK_PERIOD = 10;
    localparam count_t START      = {32'h0000_0001, 32'hFFFF_FF00};
    localparam int     WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_en = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [WORD_W-1:0] wdata = '0;
    logic [WORD_W-1:0] rdata;
    logic [NUM_CH-1:0] irq;

    int     checks = 0;
    int     errors = 0;
    int     cycles = 0;
    count_t exp_cnt = START;

    systimer_top #(.START_VALUE(START)) u_dut (
        .clk, .rst, .tick_en, .wr_en, .rd_en, .addr, .wdata, .rdata, .irq
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input word_t d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, output word_t d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
        exp_cnt = exp_cnt + count_t'(n);
    endtask

    task automatic t_reset;
        word_t v;
        bus_rd(5'h04, v); chk("R1 count low", v, exp_cnt[31:0]);
        bus_rd(5'h08, v); chk("R1 count high", v, exp_cnt[63:32]);
        bus_rd(5'h00, v); chk("R1 status", v, 0);
        chk("R1 irq", irq, 0);
        for (int i = 0; i < NUM_CH; i++) begin
            bus_rd(5'(12 + 4*i), v); chk("R1 compare", v, 0);
        end
    endtask

    task automatic t_map_rw;
        word_t v;
        for (int i = 0; i < NUM_CH; i++) bus_wr(5'(12 + 4*i), 32'hA5A5_0000 + i);
        for (int i = 0; i < NUM_CH; i++) begin
            bus_rd(5'(12 + 4*i), v); chk("R4 compare readback", v, 32'hA5A5_0000 + i);
        end
        bus_wr(5'h04, 32'hDEAD_BEEF);
        bus_wr(5'h08, 32'h1234_5678);
        bus_rd(5'h04, v); chk("R4 low write ignored", v, exp_cnt[31:0]);
        bus_rd(5'h08, v); chk("R4 high write ignored", v, exp_cnt[63:32]);
        bus_wr(5'h1C, 32'hFFFF_FFFF);
        bus_rd(5'h1C, v); chk("R3 unmapped reads zero", v, 0);
        bus_wr(5'h0D, 32'h0000_0077);
        bus_rd(5'h0C, v); chk("R3 unaligned write ignored", v, 32'hA5A5_0000);
    endtask

    task automatic t_count;
        word_t v;
        ticks(10);
        bus_rd(5'h04, v); chk("R2 ticks counted", v, exp_cnt[31:0]);
        repeat (5) @(negedge clk);
        bus_rd(5'h04, v); chk("R2 hold without tick", v, exp_cnt[31:0]);
    endtask

    task automatic t_match;
        word_t v;
        bus_wr(5'h0C, exp_cnt[31:0] + 32'd5);
        ticks(4);
        chk("R5 no early match", irq, 0);
        ticks(1);
        chk("R9 irq on match", irq, 4'b0001);
        bus_rd(5'h00, v); chk("R3 status bit0", v, 1);
    endtask

    task automatic t_w1c;
        word_t v;
        ticks(3);
        chk("R7 sticky", irq, 4'b0001);
        bus_wr(5'h00, 32'hFFFF_FFFE);
        bus_rd(5'h00, v); chk("R7 zero leaves flag", v, 1);
        bus_wr(5'h00, 32'h1);
        bus_rd(5'h00, v); chk("R7 one clears", v, 0);
        chk("R9 irq drops", irq, 0);
    endtask

    task automatic t_equal;
        word_t v;
        bus_wr(5'h10, exp_cnt[31:0]);
        repeat (3) @(negedge clk);
        ticks(2);
        bus_rd(5'h00, v); chk("R6 equal at write", v, 0);
    endtask

    task automatic t_set_wins;
        word_t v;
        bus_wr(5'h14, exp_cnt[31:0] + 32'd1);
        @(negedge clk);
        tick_en = 1'b1; wr_en = 1'b1; addr = 5'h00; wdata = 32'h4;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0; wdata = '0;
        exp_cnt = exp_cnt + 1;
        bus_rd(5'h00, v); chk("R8 set wins", v, 4);
        bus_wr(5'h00, 32'h4);
    endtask

    task automatic t_wrap;
        word_t v;
        word_t target;
        bus_rd(5'h04, v);
        target = v + 32'h0000_0100;
        bus_wr(5'h18, target);
        bus_rd(5'h04, v);
        ticks(int'(target - v) - 1);
        chk("R10 not yet", irq, 0);
        bus_rd(5'h08, v); chk("R11 stale high", v, 32'h1);
        ticks(1);
        chk("R10 wrapped match", irq, 4'b1000);
        bus_rd(5'h04, v); chk("R2 low after wrap", v, exp_cnt[31:0]);
        bus_rd(5'h08, v); chk("R11 fresh high", v, exp_cnt[63:32]);
        chk("R2 carry", exp_cnt[63:32], 64'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_map_rw;
        t_count;
        t_match;
        t_w1c;
        t_equal;
        t_set_wins;
        t_wrap;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule